// File: doc/BRIEF.md
# Wireless Module Power Sequencer

This block sits in a host chip and owns the enable and reset pins of an attached wireless module. It watches two power-good indications, one for the battery rail and one for the I/O rail, and a software-level power request. When power is requested and the battery rail is good, it asks the host regulator to bring up the I/O rail. It raises the module enable only once the I/O rail reports good. It then holds the module reset low for a programmable crystal-settle interval, 5 ms by default, before releasing it.

Power-down runs the order backwards. Enable and reset fall together, and the I/O rail request is withdrawn one cycle later. Losing either power-good while the module is up starts the same shutdown. Losing power-good, or withdrawing the request, while the settle interval is running cancels the start-up and returns the block to off without ever releasing reset.

A two-bit phase output tells the host whether the module is powered down, held in its power-on-reset phase, or running. A sticky fault flag records an I/O rail that came up while the battery rail was absent. The power-good and request inputs are asynchronous to the host clock, so each passes through its own synchronizer before the sequencing logic sees it.

Top module: `host_pwr_seq`

## Requirements
- R1: After rst_n is low at a clock edge, mod_enable, mod_reset_n, io_rail_req and fault are 0 and phase is 2'b00.
- R2: io_rail_req is asserted only while pwr_req and vbat_good are both high, and it stays low while vbat_good is low.
- R3: mod_enable rises only while io_rail_req is already high and vio_good is high. While vio_good is low, mod_enable stays low.
- R4: mod_reset_n rises exactly SETTLE_US microseconds of clock cycles (CLK_FREQ_HZ/1e6 × SETTLE_US) after mod_enable rises, and never sooner.
- R5: If pwr_req falls, or either power-good falls, during the settle interval, mod_enable and io_rail_req drop and mod_reset_n never rises.
- R6: On a power-down from the running phase, mod_enable and mod_reset_n fall on the same clock edge, and io_rail_req falls exactly one cycle later.
- R7: If vbat_good or vio_good falls while the module is running, the R6 shutdown takes place even though pwr_req stays high.
- R8: phase is 2'b00 while mod_enable is low, 2'b01 while mod_enable is high and mod_reset_n is low, and 2'b10 while both are high.
- R9: fault becomes 1 when vio_good rises while vbat_good is low. It then stays 1 until rst_n is asserted.
- R10: mod_reset_n is never high while mod_enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_req | input | 1 | Host request to power the module (asynchronous) |
| vbat_good | input | 1 | Battery rail power-good (asynchronous) |
| vio_good | input | 1 | I/O rail power-good (asynchronous) |
| mod_enable | output | 1 | Module enable pin, always driven |
| mod_reset_n | output | 1 | Module active-low reset pin |
| io_rail_req | output | 1 | Request to the host regulator to supply the I/O rail |
| phase | output | 2 | Module pin-state phase: 00 off, 01 power-on reset, 10 running |
| fault | output | 1 | Sticky flag: I/O rail came up without the battery rail |

## Verification
The bench builds the block with CLK_FREQ_HZ = 1,000,000 and SETTLE_US = 20, so the settle interval is 20 cycles instead of half a million. That makes it possible to count the exact release delay cycle by cycle and to abort in the middle of the interval. SYNC_STAGES stays at its default of 2. The vector walk therefore settles for a fixed margin after each input change, and the edge-ordering checks on shutdown measure the outputs relative to one another rather than to the input change.

// File: rtl/pwrseq_pkg.sv
// Package: shared state and phase encodings for the module power sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package pwrseq_pkg;

    // Sequencer states, in power-up order.
    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_WAIT_IO  = 3'd1,
        ST_SETTLE   = 3'd2,
        ST_RUNNING  = 3'd3,
        ST_SHUTDOWN = 3'd4
    } seq_state_t;

    // Pin-state phase codes seen by the host.
    localparam logic [1:0] PH_OFF = 2'b00;
    localparam logic [1:0] PH_POR = 2'b01;
    localparam logic [1:0] PH_RUN = 2'b10;

endpackage

// File: rtl/pwrseq_sync.sv
// Module: multi-bit level synchronizer, one flop chain per bit.
// Assumes: each bit is a slow level (power-good, request) with no
// relation between bits, so per-bit synchronization is sufficient.
// STAGES = 0 selects a plain pass-through.
module pwrseq_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q_sync = d_async;
        end else begin : g_chain
            logic [WIDTH-1:0] stage_q [STAGES];

            // Shift each bit through the flop chain; cleared in reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
                end else begin
                    stage_q[0] <= d_async;
                    for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
                end
            end

            assign q_sync = stage_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/pwrseq_settle_timer.sv
// Module: oscillator-settle cycle counter.
// Assumes: run is held high for the whole interval; dropping run clears the
// count, so every interval starts from zero. done is high in the cycle whose
// count equals LIMIT-1, which lets the FSM leave on the following edge,
// LIMIT cycles after entry.
module pwrseq_settle_timer #(
    parameter int LIMIT = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Count up while running, hold at the last value, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/pwrseq_fault_mon.sv
// Module: rail-order fault monitor.
// Assumes: inputs are already synchronized. A rising I/O power-good seen
// while battery power-good is low sets a sticky flag that only reset clears.
module pwrseq_fault_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic vbat_s,
    input  logic vio_s,
    output logic fault
);
    logic vio_prev_q;
    logic fault_q;

    // Track the previous I/O good level and latch ordering violations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vio_prev_q <= 1'b0;
            fault_q    <= 1'b0;
        end else begin
            vio_prev_q <= vio_s;
            if (vio_s && !vio_prev_q && !vbat_s) fault_q <= 1'b1;
        end
    end

    assign fault = fault_q;
endmodule

// File: rtl/pwrseq_fsm.sv
// Module: power-up/down sequencing state machine.
// Assumes: synchronized inputs; settle_done comes from a timer that runs
// while settle_run is high. Pin outputs are registered from the next-state
// decode, so they change on the same edge as the state and never glitch.
module pwrseq_fsm
    import pwrseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_s,
    input  logic       vbat_s,
    input  logic       vio_s,
    input  logic       settle_done,
    output logic       settle_run,
    output logic       en_o,
    output logic       rstn_o,
    output logic       io_req_o,
    output logic [1:0] phase_o
);
    seq_state_t state_q, state_nx;
    logic       keep_up;

    assign keep_up = req_s && vbat_s;

    // Next-state selection from the present state and synchronized inputs.
    always_comb begin
        state_nx = state_q;
        case (state_q)
            ST_OFF:      if (keep_up) state_nx = ST_WAIT_IO;
            ST_WAIT_IO: begin
                if (!keep_up)   state_nx = ST_OFF;
                else if (vio_s) state_nx = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (!keep_up || !vio_s) state_nx = ST_OFF;
                else if (settle_done)   state_nx = ST_RUNNING;
            end
            ST_RUNNING:  if (!keep_up || !vio_s) state_nx = ST_SHUTDOWN;
            ST_SHUTDOWN: state_nx = ST_OFF;
            default:     state_nx = ST_OFF;
        endcase
    end

    // State register and registered pin decode of the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_OFF;
            en_o     <= 1'b0;
            rstn_o   <= 1'b0;
            io_req_o <= 1'b0;
            phase_o  <= PH_OFF;
        end else begin
            state_q  <= state_nx;
            en_o     <= (state_nx == ST_SETTLE) || (state_nx == ST_RUNNING);
            rstn_o   <= (state_nx == ST_RUNNING);
            io_req_o <= (state_nx != ST_OFF);
            case (state_nx)
                ST_SETTLE:  phase_o <= PH_POR;
                ST_RUNNING: phase_o <= PH_RUN;
                default:    phase_o <= PH_OFF;
            endcase
        end
    end

    assign settle_run = (state_q == ST_SETTLE);
endmodule

// File: rtl/host_pwr_seq.sv
// Module: top of the host-side module power sequencer.
// Assumes: pwr_req, vbat_good and vio_good are asynchronous levels;
// CLK_FREQ_HZ is a whole number of MHz so the settle count is exact.
// Ties the synchronizer, settle timer, fault monitor and FSM together.
module host_pwr_seq #(
    parameter int CLK_FREQ_HZ = 100_000_000,
    parameter int SETTLE_US   = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_req,
    input  logic       vbat_good,
    input  logic       vio_good,
    output logic       mod_enable,
    output logic       mod_reset_n,
    output logic       io_rail_req,
    output logic [1:0] phase,
    output logic       fault
);
    localparam int CYC_PER_US = CLK_FREQ_HZ / 1_000_000;
    localparam int SETTLE_CYC = (CYC_PER_US * SETTLE_US < 1) ? 1 : CYC_PER_US * SETTLE_US;

    logic [2:0] in_sync;
    logic       settle_run;
    logic       settle_done;

    pwrseq_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({pwr_req, vbat_good, vio_good}),
        .q_sync  (in_sync)
    );

    pwrseq_settle_timer #(.LIMIT(SETTLE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (settle_run),
        .done  (settle_done)
    );

    pwrseq_fault_mon u_fault (
        .clk    (clk),
        .rst_n  (rst_n),
        .vbat_s (in_sync[1]),
        .vio_s  (in_sync[0]),
        .fault  (fault)
    );

    pwrseq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_s       (in_sync[2]),
        .vbat_s      (in_sync[1]),
        .vio_s       (in_sync[0]),
        .settle_done (settle_done),
        .settle_run  (settle_run),
        .en_o        (mod_enable),
        .rstn_o      (mod_reset_n),
        .io_req_o    (io_rail_req),
        .phase_o     (phase)
    );
endmodule

// File: rtl/host_pwr_seq_chk.sv
// Module: port-level property checker for host_pwr_seq, attached by bind.
// Assumes: same parameters as the top; counts enable-high cycles itself so
// no large $past depth is needed for the settle window.
module host_pwr_seq_chk #(
    parameter int CLK_FREQ_HZ = 100_000_000,
    parameter int SETTLE_US   = 5000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       mod_enable,
    input logic       mod_reset_n,
    input logic       io_rail_req,
    input logic [1:0] phase,
    input logic       fault
);
    localparam int CYC_PER_US = CLK_FREQ_HZ / 1_000_000;
    localparam int SETTLE_CYC = (CYC_PER_US * SETTLE_US < 1) ? 1 : CYC_PER_US * SETTLE_US;

    logic [31:0] en_cnt;

    // Count cycles since enable went high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !mod_enable) en_cnt <= '0;
        else if (en_cnt != '1)     en_cnt <= en_cnt + 1'b1;
    end

    AST_EN_AFTER_IO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_enable) |-> io_rail_req); // R3
    AST_SETTLE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_reset_n) |-> (en_cnt >= 32'(SETTLE_CYC))); // R4
    AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        mod_reset_n |-> mod_enable); // R10
    AST_IO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(io_rail_req) |-> !mod_enable); // R6
    AST_EN_RST_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mod_enable) && $past(mod_reset_n)) |-> !mod_reset_n); // R6
    AST_PHASE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_enable |-> (phase == 2'b00)); // R8
    AST_PHASE_POR: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_enable && !mod_reset_n) |-> (phase == 2'b01)); // R8
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fault) |-> fault); // R9
endmodule

bind host_pwr_seq host_pwr_seq_chk #(
    .CLK_FREQ_HZ (CLK_FREQ_HZ),
    .SETTLE_US   (SETTLE_US)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mod_enable  (mod_enable),
    .mod_reset_n (mod_reset_n),
    .io_rail_req (io_rail_req),
    .phase       (phase),
    .fault       (fault)
);

// File: tb/host_pwr_seq_test.sv
// Bench: vector walk over steady input combinations, then directed checks
// on settle timing, abort, shutdown ordering and the fault flag.
module host_pwr_seq_test;
    localparam int SETTLE = 20; // 1 MHz nominal x 20 us

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_req = 1'b0, vbat_good = 1'b0, vio_good = 1'b0;
    logic       mod_enable, mod_reset_n, io_rail_req, fault;
    logic [1:0] phase;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    host_pwr_seq #(.CLK_FREQ_HZ(1_000_000), .SETTLE_US(20), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .vbat_good(vbat_good),
        .vio_good(vio_good), .mod_enable(mod_enable), .mod_reset_n(mod_reset_n),
        .io_rail_req(io_rail_req), .phase(phase), .fault(fault)
    );

    // Vector: {req, vbat, vio, exp_en, exp_rstn, exp_io, exp_phase[1:0]}
    localparam logic [7:0] VEC [10] = '{
        8'b000_000_00, 8'b100_000_00, 8'b110_001_00, 8'b111_111_10,
        8'b011_000_00, 8'b111_111_10, 8'b110_001_00, 8'b111_111_10,
        8'b101_000_00, 8'b000_000_00
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int k, en_i, rs_i, io_i;
        bit rst_seen;
        tick(3);
        // R1: reset state
        check("R1 reset outputs", {mod_enable, mod_reset_n, io_rail_req, fault, phase}, 6'b0);
        rst_n = 1'b1;
        tick(2);

        // Vector walk: R2 R3 R6 R7 R8 steady states
        for (int v = 0; v < 10; v++) begin
            {pwr_req, vbat_good, vio_good} = VEC[v][7:5];
            tick(SETTLE + 15);
            check($sformatf("vector %0d R2 R3 R7 R8", v),
                  {mod_enable, mod_reset_n, io_rail_req, phase}, VEC[v][4:0]);
            check($sformatf("vector %0d R9 no fault", v), fault, 1'b0);
        end

        // R4 exact release delay, R8 reset phase code
        {pwr_req, vbat_good, vio_good} = 3'b111;
        while (!mod_enable) tick(1);
        check("R8 phase during settle", phase, 2'b01);
        check("R3 io request before enable", io_rail_req, 1'b1);
        k = 0;
        while (!mod_reset_n && k < 100) begin tick(1); k++; end
        check("R4 settle cycles", k, SETTLE);

        // R6 shutdown edge ordering
        pwr_req = 1'b0;
        en_i = -1; rs_i = -1; io_i = -1;
        for (int c = 0; c < 20; c++) begin
            tick(1);
            if (en_i < 0 && !mod_enable)  en_i = c;
            if (rs_i < 0 && !mod_reset_n) rs_i = c;
            if (io_i < 0 && !io_rail_req) io_i = c;
        end
        check("R6 enable and reset fall together", rs_i, en_i);
        check("R6 io request falls one cycle later", io_i, en_i + 1);
        tick(5);

        // R5 abort mid-settle
        pwr_req = 1'b1;
        while (!mod_enable) tick(1);
        tick(5);
        pwr_req = 1'b0;
        rst_seen = 1'b0;
        for (int c = 0; c < 30; c++) begin
            tick(1);
            if (mod_reset_n) rst_seen = 1'b1;
        end
        check("R5 reset never released on abort", rst_seen, 1'b0);
        check("R5 enable and io low after abort", {mod_enable, io_rail_req}, 2'b00);

        // R7 battery loss while running, request held
        pwr_req = 1'b1;
        tick(SETTLE + 15);
        vbat_good = 1'b0;
        tick(10);
        check("R7 vbat loss shuts down", {mod_enable, mod_reset_n, io_rail_req}, 3'b000);

        // R9 fault on I/O good without battery, sticky, cleared by reset
        vio_good = 1'b0; pwr_req = 1'b0;
        tick(5);
        vio_good = 1'b1;
        tick(5);
        check("R9 fault set", fault, 1'b1);
        check("R2 no io request without battery", io_rail_req, 1'b0);
        vbat_good = 1'b1;
        tick(5);
        check("R9 fault sticky", fault, 1'b1);
        rst_n = 1'b0;
        tick(2);
        check("R1 R9 reset clears fault", fault, 1'b0);
        rst_n = 1'b1;
        tick(2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule